// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a Multicycle Datapath

This block is the control unit of a multicycle 32-bit load/store processor. A small microcode store holds one microinstruction per micro-address. Each microinstruction is made of symbolic fields: ALU operation, first ALU operand, second ALU operand, register write-back target, memory action, memory-to-register write, PC update and sequencing. A decoder turns the fields of the current microinstruction into the datapath's control lines. A micro-program counter (micro-PC) picks the next microinstruction. It can fall through to the next address, return to the fetch entry, or jump through a dispatch table indexed by the instruction opcode.

A fourth sequencing choice, "loop", keeps the micro-PC on the same microinstruction while an external count-not-zero status is high, and falls through once it drops. This lets a block-clear instruction zero a run of memory words with a single repeated microinstruction. That microinstruction writes memory and decrements a datapath counter on every pass. The datapath, the register file and the counter itself sit outside this block. It sees only the opcode and the count status, and it drives the control lines. The micro-PC is brought out so that its sequencing can be observed.

Top module: `ucode_ctrl`

## Requirements
- R1: While rst_n is low, upc is 0 and every write enable is low: reg_wr, mem_wr, ir_wr, pc_wr, pc_wr_cond, cnt_load and cnt_dec.
- R2: At upc 0 (fetch), the outputs are alu_op=00 (add), sel_a=0 (PC), sel_b=000 (constant 4), mem_rd=1, addr_alu=0, ir_wr=1 and pc_wr=1, with every other enable low. The next upc is 1.
- R3: At upc 1 (dispatch), the outputs are alu_op=00, sel_a=0 and sel_b=100 (sign-extended immediate shifted left by 2), with no enable high. The next upc is taken from the opcode: 0x00 goes to 7, 0x23 to 2, 0x2B to 5, 0x0D to 9, 0x04 to 11 and 0x3C to 12.
- R4: Any other opcode at dispatch sends upc to 0.
- R5: The load-word program runs at upc 2, then 3, then 4, then 0. Upc 2 drives sel_a=1 (rs) and sel_b=010 (sign-extended). Upc 3 drives mem_rd=1 and addr_alu=1. Upc 4 drives reg_wr=1 and mem_to_reg=1 with reg_dst_rd=0.
- R6: The store-word program runs at upc 5, then 6, then 0. Upc 5 drives sel_a=1 and sel_b=010. Upc 6 drives mem_wr=1 and addr_alu=1.
- R7: The register-register program runs at upc 7, then 8, then 0. Upc 7 drives alu_op=10 (function field), sel_a=1 and sel_b=001 (rt). Upc 8 drives reg_wr=1 and reg_dst_rd=1.
- R8: The OR-immediate program runs at upc 9, then 10, then 0. Upc 9 drives alu_op=11, sel_a=1 and sel_b=011 (zero-extended). Upc 10 drives reg_wr=1 with reg_dst_rd=0 and mem_to_reg=0.
- R9: The branch program is upc 11, then 0. Upc 11 drives alu_op=01, sel_a=1, sel_b=001, pc_wr_cond=1 and pc_src_aluout=1.
- R10: The block-clear program runs as follows. Upc 12 drives cnt_load=1 and moves on to 13. Upc 13 drives mem_wr=1, addr_alu=1 and cnt_dec=1. It stays at 13 while cnt_nz=1 and moves to 14 when cnt_nz=0. Upc 14 drives no enable and returns to 0.
- R11: cnt_nz has no effect on the sequence at any upc other than 13.
- R12: Whenever pc_wr is high, pc_src_aluout is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction register, used at dispatch |
| cnt_nz | input | 1 | Block counter not yet zero |
| upc | output | 4 | Current micro-PC |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field, 11 OR |
| sel_a | output | 1 | First ALU operand: 0 PC, 1 rs |
| sel_b | output | 3 | Second ALU operand: 000 four, 001 rt, 010 sign-ext, 011 zero-ext, 100 sign-ext shifted |
| reg_wr | output | 1 | Register file write enable |
| reg_dst_rd | output | 1 | Write target is rd (else rt) |
| mem_to_reg | output | 1 | Write-back data comes from memory |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write (data is rt) |
| addr_alu | output | 1 | Memory address from ALUout (else PC) |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load from ALU result |
| pc_wr_cond | output | 1 | PC load when the ALU zero flag is set |
| pc_src_aluout | output | 1 | PC source is ALUout (else ALU result) |
| cnt_load | output | 1 | Load the block counter |
| cnt_dec | output | 1 | Decrement the block counter |

## Verification
The case that matters is the loop-exit decision falling in the same cycle as a reset. It also matters when a cnt_nz change falls in a cycle whose microinstruction is not the loop. To provoke the first, the bench raises reset in the middle of a long block-clear hold while cnt_nz is still high. It then expects upc 0 with all enables low at once, and a clean fetch after release. For the second, the bench drives cnt_nz at random in every cycle outside the loop, including fetch and dispatch. A behavioural model of the next micro-address judges each cycle, and a mismatch is reported against the requirement for that transition.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
   typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_OR = 2'd3} alu_f_e;
   typedef enum logic {SA_PC = 1'b0, SA_RS = 1'b1} srca_e;
   typedef enum logic [2:0] {SB_FOUR = 3'd0, SB_RT = 3'd1, SB_SEXT = 3'd2, SB_ZEXT = 3'd3, SB_SHFT = 3'd4} srcb_e;
   typedef enum logic [1:0] {DST_NONE = 2'd0, DST_RD = 2'd1, DST_RT = 2'd2} dest_e;
   typedef enum logic [1:0] {MEM_NONE = 2'd0, MEM_RD_PC = 2'd1, MEM_RD_ALU = 2'd2, MEM_WR_ALU = 2'd3} mem_e;
   typedef enum logic [1:0] {PCW_NONE = 2'd0, PCW_ALU = 2'd1, PCW_COND = 2'd2} pcw_e;
   typedef enum logic [1:0] {CNT_NONE = 2'd0, CNT_LOAD = 2'd1, CNT_DEC = 2'd2} cnt_e;
   typedef enum logic [1:0] {SQ_NEXT = 2'd0, SQ_FETCH = 2'd1, SQ_DISP = 2'd2, SQ_LOOP = 2'd3} seq_e;

   typedef struct packed {
      alu_f_e alu;
      srca_e  sa;
      srcb_e  sb;
      dest_e  dst;
      mem_e   mem;
      logic   mreg;
      pcw_e   pcw;
      cnt_e   cnt;
      seq_e   seq;
   } uinst_t;

   // entry points of the micro-programs
   localparam int UA_FETCH = 0;
   localparam int UA_DISP  = 1;
   localparam int UA_LW    = 2;
   localparam int UA_SW    = 5;
   localparam int UA_RR    = 7;
   localparam int UA_ORI   = 9;
   localparam int UA_BEQ   = 11;
   localparam int UA_BZ    = 12;
   localparam int UA_COUNT = 15;

   localparam logic [5:0] OPC_RR  = 6'h00;
   localparam logic [5:0] OPC_LW  = 6'h23;
   localparam logic [5:0] OPC_SW  = 6'h2B;
   localparam logic [5:0] OPC_ORI = 6'h0D;
   localparam logic [5:0] OPC_BEQ = 6'h04;
   localparam logic [5:0] OPC_BZ  = 6'h3C;
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic [UPC_W-1:0] upc,
   output uinst_t           ui
);
   localparam int DEPTH = 1 << UPC_W;

   if (DEPTH < UA_COUNT) begin : g_depth_chk
      $error("ucode_rom: UPC_W too small for the microprogram");
   end

   always_comb begin
      int unsigned a;
      a = upc;
      ui = '0;
      ui.seq = SQ_FETCH;
      case (a)
         UA_FETCH: begin
            ui.mem = MEM_RD_PC; ui.pcw = PCW_ALU; ui.seq = SQ_NEXT;
         end
         UA_DISP: begin
            ui.sb = SB_SHFT; ui.seq = SQ_DISP;
         end
         UA_LW: begin
            ui.sa = SA_RS; ui.sb = SB_SEXT; ui.seq = SQ_NEXT;
         end
         UA_LW + 1: begin
            ui.mem = MEM_RD_ALU; ui.seq = SQ_NEXT;
         end
         UA_LW + 2: ui.mreg = 1'b1;
         UA_SW: begin
            ui.sa = SA_RS; ui.sb = SB_SEXT; ui.seq = SQ_NEXT;
         end
         UA_SW + 1: ui.mem = MEM_WR_ALU;
         UA_RR: begin
            ui.alu = ALU_FUNC; ui.sa = SA_RS; ui.sb = SB_RT; ui.seq = SQ_NEXT;
         end
         UA_RR + 1: ui.dst = DST_RD;
         UA_ORI: begin
            ui.alu = ALU_OR; ui.sa = SA_RS; ui.sb = SB_ZEXT; ui.seq = SQ_NEXT;
         end
         UA_ORI + 1: ui.dst = DST_RT;
         UA_BEQ: begin
            ui.alu = ALU_SUB; ui.sa = SA_RS; ui.sb = SB_RT; ui.pcw = PCW_COND;
         end
         UA_BZ: begin
            ui.cnt = CNT_LOAD; ui.seq = SQ_NEXT;
         end
         UA_BZ + 1: begin
            ui.mem = MEM_WR_ALU; ui.cnt = CNT_DEC; ui.seq = SQ_LOOP;
         end
         default: ui.seq = SQ_FETCH;
      endcase
   end
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
   import ucode_pkg::*;
#(
   parameter int OP_W  = 6,
   parameter int UPC_W = 4
) (
   input  logic [OP_W-1:0]  opcode,
   output logic             hit,
   output logic [UPC_W-1:0] entry
);
   if (OP_W != 6) begin : g_op_chk
      $error("ucode_dispatch: opcode width must be 6");
   end

   always_comb begin
      hit   = 1'b1;
      entry = '0;
      case (opcode)
         OPC_RR:  entry = UPC_W'(UA_RR);
         OPC_LW:  entry = UPC_W'(UA_LW);
         OPC_SW:  entry = UPC_W'(UA_SW);
         OPC_ORI: entry = UPC_W'(UA_ORI);
         OPC_BEQ: entry = UPC_W'(UA_BEQ);
         OPC_BZ:  entry = UPC_W'(UA_BZ);
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int UPC_W   = 4,
   parameter bit LOOP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_e             seq,
   input  logic             disp_hit,
   input  logic [UPC_W-1:0] disp_entry,
   input  logic             cnt_nz,
   output logic [UPC_W-1:0] upc
);
   logic             loop_stay;
   logic [UPC_W-1:0] upc_q, upc_d, upc_inc;

   if (LOOP_EN) begin : g_loop
      assign loop_stay = cnt_nz;
   end else begin : g_noloop
      assign loop_stay = 1'b0;
   end

   assign upc_inc = upc_q + UPC_W'(1);

   always_comb begin
      case (seq)
         SQ_NEXT:  upc_d = upc_inc;
         SQ_DISP:  upc_d = disp_hit ? disp_entry : '0;
         SQ_LOOP:  upc_d = loop_stay ? upc_q : upc_inc;
         default:  upc_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc_q <= '0;
      else        upc_q <= upc_d;
   end

   assign upc = upc_q;

   // R2
   fetch_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SQ_FETCH) |=> (upc_q == '0));
   // R4
   disp_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SQ_DISP && !disp_hit) |=> (upc_q == '0));
   // R11
   next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SQ_NEXT) |=> (upc_q == $past(upc_q) + UPC_W'(1)));
   // R10
   loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SQ_LOOP && !cnt_nz) |=> (upc_q == $past(upc_q) + UPC_W'(1)));
   if (LOOP_EN) begin : g_loop_chk
      // R10
      loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (seq == SQ_LOOP && cnt_nz) |=> $stable(upc_q));
   end
endmodule

// File: rtl/ucode_decode.sv
module ucode_decode
   import ucode_pkg::*;
(
   input  uinst_t     ui,
   output logic [1:0] alu_op,
   output logic       sel_a,
   output logic [2:0] sel_b,
   output logic       reg_wr,
   output logic       reg_dst_rd,
   output logic       mem_to_reg,
   output logic       mem_rd,
   output logic       mem_wr,
   output logic       addr_alu,
   output logic       ir_wr,
   output logic       pc_wr,
   output logic       pc_wr_cond,
   output logic       pc_src_aluout,
   output logic       cnt_load,
   output logic       cnt_dec
);
   assign alu_op        = ui.alu;
   assign sel_a         = ui.sa;
   assign sel_b         = ui.sb;
   assign reg_wr        = (ui.dst != DST_NONE) || ui.mreg;
   assign reg_dst_rd    = (ui.dst == DST_RD);
   assign mem_to_reg    = ui.mreg;
   assign mem_rd        = (ui.mem == MEM_RD_PC) || (ui.mem == MEM_RD_ALU);
   assign mem_wr        = (ui.mem == MEM_WR_ALU);
   assign addr_alu      = (ui.mem == MEM_RD_ALU) || (ui.mem == MEM_WR_ALU);
   assign ir_wr         = (ui.mem == MEM_RD_PC);
   assign pc_wr         = (ui.pcw == PCW_ALU);
   assign pc_wr_cond    = (ui.pcw == PCW_COND);
   assign pc_src_aluout = (ui.pcw == PCW_COND);
   assign cnt_load      = (ui.cnt == CNT_LOAD);
   assign cnt_dec       = (ui.cnt == CNT_DEC);
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
   import ucode_pkg::*;
#(
   parameter int OP_W    = 6,
   parameter int UPC_W   = 4,
   parameter bit LOOP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  opcode,
   input  logic             cnt_nz,
   output logic [UPC_W-1:0] upc,
   output logic [1:0]       alu_op,
   output logic             sel_a,
   output logic [2:0]       sel_b,
   output logic             reg_wr,
   output logic             reg_dst_rd,
   output logic             mem_to_reg,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             addr_alu,
   output logic             ir_wr,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic             pc_src_aluout,
   output logic             cnt_load,
   output logic             cnt_dec
);
   uinst_t           ui;
   logic             hit;
   logic [UPC_W-1:0] entry;
   logic             reg_wr_i, mem_wr_i, ir_wr_i, pc_wr_i, pc_wr_cond_i, cnt_load_i, cnt_dec_i;

   ucode_seq #(.UPC_W(UPC_W), .LOOP_EN(LOOP_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .seq(ui.seq), .disp_hit(hit),
      .disp_entry(entry), .cnt_nz(cnt_nz), .upc(upc));

   ucode_rom #(.UPC_W(UPC_W)) u_rom (.upc(upc), .ui(ui));

   ucode_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W)) u_disp (
      .opcode(opcode), .hit(hit), .entry(entry));

   ucode_decode u_dec (
      .ui(ui), .alu_op(alu_op), .sel_a(sel_a), .sel_b(sel_b),
      .reg_wr(reg_wr_i), .reg_dst_rd(reg_dst_rd), .mem_to_reg(mem_to_reg),
      .mem_rd(mem_rd), .mem_wr(mem_wr_i), .addr_alu(addr_alu), .ir_wr(ir_wr_i),
      .pc_wr(pc_wr_i), .pc_wr_cond(pc_wr_cond_i), .pc_src_aluout(pc_src_aluout),
      .cnt_load(cnt_load_i), .cnt_dec(cnt_dec_i));

   // write enables held off while reset is applied
   assign reg_wr     = reg_wr_i     & rst_n;
   assign mem_wr     = mem_wr_i     & rst_n;
   assign ir_wr      = ir_wr_i      & rst_n;
   assign pc_wr      = pc_wr_i      & rst_n;
   assign pc_wr_cond = pc_wr_cond_i & rst_n;
   assign cnt_load   = cnt_load_i   & rst_n;
   assign cnt_dec    = cnt_dec_i    & rst_n;

   // R12
   pc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr |-> !pc_src_aluout);
   // R10
   bz_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> (cnt_dec && mem_wr));
endmodule

// File: tb/tb_ucode_ctrl.sv
`timescale 1ns/1ps
module tb_ucode_ctrl;
   localparam int NPROG = 14;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;
   logic       cnt_nz = 1'b0;
   logic [3:0] upc;
   logic [1:0] alu_op;
   logic [2:0] sel_b;
   logic sel_a, reg_wr, reg_dst_rd, mem_to_reg, mem_rd, mem_wr, addr_alu, ir_wr;
   logic pc_wr, pc_wr_cond, pc_src_aluout, cnt_load, cnt_dec;

   int tests = 0, fails = 0;
   int ref_upc = 0;
   string ref_tag = "R1";
   int idx = 0;
   int rem = 0;

   always #2.5 clk = ~clk;

   ucode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .cnt_nz(cnt_nz), .upc(upc),
      .alu_op(alu_op), .sel_a(sel_a), .sel_b(sel_b), .reg_wr(reg_wr),
      .reg_dst_rd(reg_dst_rd), .mem_to_reg(mem_to_reg), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .addr_alu(addr_alu), .ir_wr(ir_wr), .pc_wr(pc_wr),
      .pc_wr_cond(pc_wr_cond), .pc_src_aluout(pc_src_aluout),
      .cnt_load(cnt_load), .cnt_dec(cnt_dec));

   function automatic logic [5:0] prog_op(int i);
      case (i)
         0: return 6'h00;  1: return 6'h23;  2: return 6'h2B;  3: return 6'h0D;
         4: return 6'h04;  5: return 6'h3C;  6: return 6'h3C;  7: return 6'h15;
         8: return 6'h3C;  9: return 6'h3F; 10: return 6'h3C; 11: return 6'h23;
         12: return 6'h3C; 13: return 6'h04;
         default: return 6'h3F;
      endcase
   endfunction

   function automatic int prog_k(int i);
      case (i)
         6: return 3; 8: return 1; 10: return 6; 12: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int disp_of(logic [5:0] op);
      case (op)
         6'h00: return 7;  6'h23: return 2;  6'h2B: return 5;
         6'h0D: return 9;  6'h04: return 11; 6'h3C: return 12;
         default: return 0;
      endcase
   endfunction

   function automatic int next_of(int a, logic [5:0] op, logic nz);
      case (a)
         0: return 1;
         1: return disp_of(op);
         2, 3, 5, 7, 9, 12: return a + 1;
         13: return nz ? 13 : 14;
         default: return 0;
      endcase
   endfunction

   // {alu_op, sel_a, sel_b, reg_wr, reg_dst_rd, mem_to_reg, mem_rd, mem_wr,
   //  addr_alu, ir_wr, pc_wr, pc_wr_cond, pc_src_aluout, cnt_load, cnt_dec}
   function automatic logic [17:0] exp_ctl(int a);
      logic [1:0] op; logic sa; logic [2:0] sb; logic [11:0] en;
      op = 2'b00; sa = 1'b0; sb = 3'b000; en = '0;
      case (a)
         0:  en = 12'b000_100_1100_00;
         1:  sb = 3'b100;
         2:  begin sa = 1'b1; sb = 3'b010; end
         3:  en = 12'b000_101_0000_00;
         4:  en = 12'b101_000_0000_00;
         5:  begin sa = 1'b1; sb = 3'b010; end
         6:  en = 12'b000_011_0000_00;
         7:  begin op = 2'b10; sa = 1'b1; sb = 3'b001; end
         8:  en = 12'b110_000_0000_00;
         9:  begin op = 2'b11; sa = 1'b1; sb = 3'b011; end
         10: en = 12'b100_000_0000_00;
         11: begin op = 2'b01; sa = 1'b1; sb = 3'b001; en = 12'b000_000_0011_00; end
         12: en = 12'b000_000_0000_10;
         13: en = 12'b000_011_0000_01;
         default: en = '0;
      endcase
      return {op, sa, sb, en};
   endfunction

   function automatic string ctl_tag(int a);
      case (a)
         0: return "R2";  1: return "R3";
         2, 3, 4: return "R5";  5, 6: return "R6";  7, 8: return "R7";
         9, 10: return "R8";  11: return "R9";
         default: return "R10";
      endcase
   endfunction

   // behavioural reference of the micro-PC
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_upc <= 0;
         ref_tag <= "R1";
      end else begin
         ref_upc <= next_of(ref_upc, opcode, cnt_nz);
         if (ref_upc == 1) ref_tag <= (disp_of(opcode) == 0) ? "R4" : "R3";
         else if (ref_upc == 13) ref_tag <= "R10";
         else ref_tag <= "R11";
      end
   end

   // compare, then drive the next inputs
   always @(negedge clk) begin
      logic [17:0] act;
      act = {alu_op, sel_a, sel_b, reg_wr, reg_dst_rd, mem_to_reg, mem_rd, mem_wr,
             addr_alu, ir_wr, pc_wr, pc_wr_cond, pc_src_aluout, cnt_load, cnt_dec};
      if (!rst_n) begin
         tests++;
         if (upc !== 4'd0 || {reg_wr, mem_wr, ir_wr, pc_wr, pc_wr_cond, cnt_load, cnt_dec} !== 7'b0) begin
            fails++;
            $display("FAIL R1 reset: upc=%0d enables=%b expected upc=0 enables=0000000", upc,
                     {reg_wr, mem_wr, ir_wr, pc_wr, pc_wr_cond, cnt_load, cnt_dec});
         end
      end else begin
         tests++;
         if (upc !== 4'(ref_upc)) begin
            fails++;
            $display("FAIL %s sequencing: upc=%0d expected %0d", ref_tag, upc, ref_upc);
         end
         tests++;
         if (act !== exp_ctl(ref_upc)) begin
            fails++;
            $display("FAIL %s controls at upc %0d: got %b expected %b", ctl_tag(ref_upc),
                     ref_upc, act, exp_ctl(ref_upc));
         end
         if (pc_wr === 1'b1) begin
            tests++;
            if (pc_src_aluout !== 1'b0) begin
               fails++;
               $display("FAIL R12 pc source: pc_src_aluout=%b expected 0", pc_src_aluout);
            end
         end
      end
      // stimulus for the coming edge
      opcode <= 6'($urandom);
      cnt_nz <= 1'($urandom);
      if (rst_n && ref_upc == 1) begin
         opcode <= prog_op(idx);
         rem    <= prog_k(idx);
         idx    <= idx + 1;
      end else if (rst_n && ref_upc == 13) begin
         cnt_nz <= (rem > 0);
         if (rem > 0) rem <= rem - 1;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset in the middle of a block-clear hold (R1 against R10)
      wait (idx == 11 && ref_upc == 13);
      @(posedge clk);
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      wait (idx == NPROG && ref_upc == 0);
      repeat (3) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule